// File: doc/BRIEF.md
# SD host interrupt status bank

This block keeps the interrupt state of an SD/MMC host controller. Two status words are held side by side. The first covers card and transfer events. The second covers protocol errors and data-buffer readiness. Each status word has its own mask word. The command engine, the data engine and the card-detect logic report what happened through one-cycle event pulses or level inputs. The block turns these into sticky bits that software reads and acknowledges over a simple register bus. A single interrupt line is raised whenever a latched bit is set and not masked.

Some bits in the status words do not latch. The card-present state, the DAT0 line level and the command-busy flag are shown as they are at that moment, and writes do not affect them. Card insertion and removal are found from the edges of the card-present level. The read-buffer and write-buffer ready flags also latch on rising edges of their level inputs, not on the levels. Acknowledging such a flag while its buffer is still full therefore leaves it clear until the buffer fills again. Both edge detectors treat the state before reset as card absent and buffers not ready.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every latched bit reads 0 and every mask bit reads 1: the first mask word reads 0x0000001D, the second reads 0x0000837F, and irq is 0.
- R2: In the first status word (byte address 0x038), an ev_rsp_done pulse sets bit 0 and an ev_data_done pulse sets bit 2. A bit set by an event reads back at the first read after the clock edge that sampled the event.
- R3: Bit 5 of the first status word mirrors card_present. A rising edge of card_present sets bit 4 (inserted) and a falling edge sets bit 3 (removed).
- R4: In the second status word (byte address 0x03C), ev_err[i] sets bit i for i = 0..6, and an ev_illegal_access pulse sets bit 15.
- R5: A rising edge of rd_buf_full sets bit 8 and a rising edge of wr_buf_empty sets bit 9. If bit 8 is cleared while rd_buf_full stays high, it stays clear until the next rising edge.
- R6: Bit 7 of the second status word mirrors dat0_level and bit 14 mirrors cmd_busy. Writes to the status word leave these bits unchanged.
- R7: A write to a status word clears each latched bit whose write-data bit is 0 and leaves alone each latched bit whose write-data bit is 1.
- R8: If an event and a clear for the same bit happen in the same cycle, the bit ends up set.
- R9: The mask words sit at byte addresses 0x040 (first) and 0x044 (second). Only the latched positions are stored and read back, and other bits read 0. A mask bit of 1 blocks its status bit. irq is the OR of all latched, unmasked bits, and live bits never drive it.
- R10: A read from any other address returns 0. A write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational, 0 when not reading) |
| ev_rsp_done | input | 1 | Response-complete pulse |
| ev_data_done | input | 1 | Data-complete pulse |
| card_present | input | 1 | Card-detect level |
| rd_buf_full | input | 1 | Read buffer holds a block (level) |
| wr_buf_empty | input | 1 | Write buffer can take a block (level) |
| ev_err | input | 7 | Error pulses, bit i maps to status bit i |
| ev_illegal_access | input | 1 | Illegal-access error pulse |
| dat0_level | input | 1 | Current DAT0 line level |
| cmd_busy | input | 1 | Command engine busy level |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: a 12-bit byte address and a 32-bit data word. With these the four register offsets decode exactly, and the unused addresses next to them, such as 0x034 and 0x048, can be reached to test the decode. The 32-bit word holds every named bit position, so the readback of masks and status shows that the gaps between fields stay at zero when all-ones values are written. The scenarios cover a clear and a set in the same cycle, and acknowledging a ready flag while its buffer level is still high. They also check that live bits never raise the interrupt, even with all masks open.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned NUM_ERR   = 7;

    // register byte offsets
    localparam logic [31:0] OFS_STAT_A = 32'h038;
    localparam logic [31:0] OFS_STAT_B = 32'h03C;
    localparam logic [31:0] OFS_MASK_A = 32'h040;
    localparam logic [31:0] OFS_MASK_B = 32'h044;

    // first status word bit positions
    localparam int unsigned A_RSP    = 0;
    localparam int unsigned A_DATA   = 2;
    localparam int unsigned A_REMOVE = 3;
    localparam int unsigned A_INSERT = 4;
    localparam int unsigned A_CDLIVE = 5;

    // second status word bit positions
    localparam int unsigned B_ERR0   = 0;
    localparam int unsigned B_DAT0   = 7;
    localparam int unsigned B_RDRDY  = 8;
    localparam int unsigned B_WRRDY  = 9;
    localparam int unsigned B_BUSY   = 14;
    localparam int unsigned B_ILLACC = 15;

    localparam logic [31:0] LAT_A  = (32'd1 << A_RSP) | (32'd1 << A_DATA)
                                   | (32'd1 << A_REMOVE) | (32'd1 << A_INSERT);
    localparam logic [31:0] LIVE_A = (32'd1 << A_CDLIVE);
    localparam logic [31:0] LAT_B  = (((32'd1 << NUM_ERR) - 32'd1) << B_ERR0)
                                   | (32'd1 << B_RDRDY) | (32'd1 << B_WRRDY)
                                   | (32'd1 << B_ILLACC);
    localparam logic [31:0] LIVE_B = (32'd1 << B_DAT0) | (32'd1 << B_BUSY);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT_A,
        SEL_STAT_B,
        SEL_MASK_A,
        SEL_MASK_B
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        case (a)
            OFS_STAT_A: return SEL_STAT_A;
            OFS_STAT_B: return SEL_STAT_B;
            OFS_MASK_A: return SEL_MASK_A;
            OFS_MASK_B: return SEL_MASK_B;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdh_irq_edge.sv
// Rising-edge finder for a vector of level inputs.
module sdh_irq_edge #(
    parameter int unsigned     W        = 1,
    parameter logic [W-1:0]    PREV_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PREV_RST;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sdh_irq_bank.sv
// One status word with its mask: sticky bits, write-zero-to-clear, live overlay.
module sdh_irq_bank #(
    parameter int unsigned   DW       = 32,
    parameter logic [DW-1:0] LAT_MSK  = '0,
    parameter logic [DW-1:0] LIVE_MSK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] live_vec,
    output logic [DW-1:0] stat_rd,
    output logic [DW-1:0] mask_rd,
    output logic          pend
);
    typedef struct packed {
        logic [DW-1:0] lat;
        logic [DW-1:0] msk;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat) st_d.lat = st_q.lat & wdata;
        // a new event overrides a clear in the same cycle
        st_d.lat = (st_d.lat | set_vec) & LAT_MSK;
        if (wr_mask) st_d.msk = wdata & LAT_MSK;

        stat_rd = st_q.lat | (live_vec & LIVE_MSK);
        mask_rd = st_q.msk;
        pend    = |(st_q.lat & ~st_q.msk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '0;
            st_q.msk <= LAT_MSK;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               ev_rsp_done,
    input  logic               ev_data_done,
    input  logic               card_present,
    input  logic               rd_buf_full,
    input  logic               wr_buf_empty,
    input  logic [NUM_ERR-1:0] ev_err,
    input  logic               ev_illegal_access,
    input  logic               dat0_level,
    input  logic               cmd_busy,
    output logic               irq
);
    localparam int unsigned NLVL = 3;

    reg_sel_e               sel;
    logic                   wr_en;
    logic [NUM_BANKS-1:0]   wr_stat, wr_mask, pend;
    logic [DW-1:0]          set_vec  [NUM_BANKS];
    logic [DW-1:0]          live_vec [NUM_BANKS];
    logic [DW-1:0]          stat_rd  [NUM_BANKS];
    logic [DW-1:0]          mask_rd  [NUM_BANKS];
    logic [NLVL-1:0]        lvl_rise;
    logic [0:0]             cd_fall;

    // signals brought out for the bound checker
    logic          wr_stat_a, wr_stat_b;
    logic [DW-1:0] stat_a_v, stat_b_v, mask_a_v, mask_b_v;

    always_comb begin
        sel   = decode_addr(32'(bus_addr));
        wr_en = bus_sel && bus_wr;
        wr_stat[0] = wr_en && (sel == SEL_STAT_A);
        wr_stat[1] = wr_en && (sel == SEL_STAT_B);
        wr_mask[0] = wr_en && (sel == SEL_MASK_A);
        wr_mask[1] = wr_en && (sel == SEL_MASK_B);
    end

    // edges of card-present and buffer levels; all assume "inactive" before reset
    sdh_irq_edge #(.W(NLVL), .PREV_RST('0)) u_edge_lvl (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({wr_buf_empty, rd_buf_full, card_present}),
        .rise (lvl_rise)
    );

    sdh_irq_edge #(.W(1), .PREV_RST(1'b1)) u_edge_rm (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (~card_present),
        .rise (cd_fall)
    );

    always_comb begin
        set_vec[0]            = '0;
        set_vec[0][A_RSP]     = ev_rsp_done;
        set_vec[0][A_DATA]    = ev_data_done;
        set_vec[0][A_REMOVE]  = cd_fall[0];
        set_vec[0][A_INSERT]  = lvl_rise[0];
        live_vec[0]           = '0;
        live_vec[0][A_CDLIVE] = card_present;

        set_vec[1]                        = '0;
        set_vec[1][B_ERR0 +: NUM_ERR]     = ev_err;
        set_vec[1][B_RDRDY]               = lvl_rise[1];
        set_vec[1][B_WRRDY]               = lvl_rise[2];
        set_vec[1][B_ILLACC]              = ev_illegal_access;
        live_vec[1]                       = '0;
        live_vec[1][B_DAT0]               = dat0_level;
        live_vec[1][B_BUSY]               = cmd_busy;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [DW-1:0] LAT  = (g == 0) ? DW'(LAT_A)  : DW'(LAT_B);
        localparam logic [DW-1:0] LIVE = (g == 0) ? DW'(LIVE_A) : DW'(LIVE_B);

        sdh_irq_bank #(.DW(DW), .LAT_MSK(LAT), .LIVE_MSK(LIVE)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stat (wr_stat[g]),
            .wr_mask (wr_mask[g]),
            .wdata   (bus_wdata),
            .set_vec (set_vec[g]),
            .live_vec(live_vec[g]),
            .stat_rd (stat_rd[g]),
            .mask_rd (mask_rd[g]),
            .pend    (pend[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                SEL_STAT_A: bus_rdata = stat_rd[0];
                SEL_STAT_B: bus_rdata = stat_rd[1];
                SEL_MASK_A: bus_rdata = mask_rd[0];
                SEL_MASK_B: bus_rdata = mask_rd[1];
                default:    bus_rdata = '0;
            endcase
        end
        irq = |pend;

        wr_stat_a = wr_stat[0];
        wr_stat_b = wr_stat[1];
        stat_a_v  = stat_rd[0];
        stat_b_v  = stat_rd[1];
        mask_a_v  = mask_rd[0];
        mask_b_v  = mask_rd[1];
    end
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk
    import sdh_irq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stat_a,
    input logic          wr_stat_b,
    input logic [DW-1:0] bus_wdata,
    input logic          ev_rsp_done,
    input logic          ev_data_done,
    input logic          ev_illegal_access,
    input logic          card_present,
    input logic          rd_buf_full,
    input logic [DW-1:0] stat_a,
    input logic [DW-1:0] stat_b,
    input logic [DW-1:0] mask_a,
    input logic [DW-1:0] mask_b,
    input logic          irq
);
    localparam logic [DW-1:0] LA = DW'(LAT_A);
    localparam logic [DW-1:0] LB = DW'(LAT_B);

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2: a response event shows up after the sampling edge
    assert_rsp_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rsp_done |=> stat_a[A_RSP]);

    // R3: insertion edge latches the inserted flag
    assert_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && card_present && !$past(card_present)) |=> stat_a[A_INSERT]);

    // R4: illegal access latches bit 15
    assert_illacc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_illegal_access |=> stat_b[B_ILLACC]);

    // R5: clearing the read-ready flag while the level holds keeps it clear
    assert_rdrdy_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && wr_stat_b && !bus_wdata[B_RDRDY] && rd_buf_full && $past(rd_buf_full))
        |=> !stat_b[B_RDRDY]);

    // R7: writing zero with no event leaves no latched bit in the first word
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && wr_stat_a && (bus_wdata == '0) && !ev_rsp_done && !ev_data_done
         && (card_present == $past(card_present)))
        |=> ((stat_a & LA) == '0));

    // R9: interrupt line agrees with latched, unmasked bits
    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (((stat_a & LA & ~mask_a) | (stat_b & LB & ~mask_b)) != '0));
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.DW(DW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_stat_a        (wr_stat_a),
    .wr_stat_b        (wr_stat_b),
    .bus_wdata        (bus_wdata),
    .ev_rsp_done      (ev_rsp_done),
    .ev_data_done     (ev_data_done),
    .ev_illegal_access(ev_illegal_access),
    .card_present     (card_present),
    .rd_buf_full      (rd_buf_full),
    .stat_a           (stat_a_v),
    .stat_b           (stat_b_v),
    .mask_a           (mask_a_v),
    .mask_b           (mask_b_v),
    .irq              (irq)
);

// File: tb/sdh_irq_status_bench.sv
module sdh_irq_status_bench;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ev_rsp_done = 1'b0, ev_data_done = 1'b0;
    logic          card_present = 1'b0, rd_buf_full = 1'b0, wr_buf_empty = 1'b0;
    logic [6:0]    ev_err = '0;
    logic          ev_illegal_access = 1'b0, dat0_level = 1'b0, cmd_busy = 1'b0;
    logic          irq;

    always #10 clk = ~clk;

    sdh_irq_status #(.AW(AW), .DW(DW)) u_sdh_irq_status (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rsp_done(ev_rsp_done), .ev_data_done(ev_data_done),
        .card_present(card_present), .rd_buf_full(rd_buf_full),
        .wr_buf_empty(wr_buf_empty), .ev_err(ev_err),
        .ev_illegal_access(ev_illegal_access), .dat0_level(dat0_level),
        .cmd_busy(cmd_busy), .irq(irq)
    );

    localparam logic [AW-1:0] SA = 12'h038, SB = 12'h03C, MA = 12'h040, MB = 12'h044;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    total = 0, bad = 0;
    bit    probe = 1'b0;
    bit    done  = 1'b0;

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        #5;
        if (probe) begin
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sbq.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; probe = 1'b0;
        ev_rsp_done = 1'b0; ev_data_done = 1'b0;
        ev_err = '0; ev_illegal_access = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sbq.push_back('{1'b0, e, tag});
        probe = 1'b1;
        tick();
    endtask

    task automatic irq_chk(input bit e, input string tag);
        @(negedge clk);
        sbq.push_back('{1'b1, {31'd0, e}, tag});
        probe = 1'b1;
        tick();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd_chk(SA, 32'h0,    "R1 stat A reset");
        rd_chk(SB, 32'h0,    "R1 stat B reset");
        rd_chk(MA, 32'h1D,   "R1 mask A reset");
        rd_chk(MB, 32'h837F, "R1 mask B reset");
        irq_chk(1'b0,        "R1 irq reset");

        // R2 / R9: response event, masked then unmasked
        @(negedge clk); ev_rsp_done = 1'b1; tick();
        rd_chk(SA, 32'h01, "R2 response bit");
        irq_chk(1'b0,      "R9 masked event");
        wr(MA, 32'h0);
        irq_chk(1'b1,      "R9 unmasked event");
        @(negedge clk); ev_data_done = 1'b1; tick();
        rd_chk(SA, 32'h05, "R2 data bit");

        // R7: write-one keeps, write-zero clears
        wr(SA, 32'hFFFF_FFFF);
        rd_chk(SA, 32'h05, "R7 ones keep");
        wr(SA, 32'hFFFF_FFFE);
        rd_chk(SA, 32'h04, "R7 selective clear");
        wr(SA, 32'h0);
        rd_chk(SA, 32'h00, "R7 full clear");
        irq_chk(1'b0,      "R9 irq drops after clear");

        // R8: event and clear together
        @(negedge clk);
        ev_data_done = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = SA; bus_wdata = 32'h0;
        tick();
        rd_chk(SA, 32'h04, "R8 set beats clear");
        wr(SA, 32'h0);

        // R3: card insert / remove
        @(negedge clk); card_present = 1'b1; tick();
        rd_chk(SA, 32'h30, "R3 insert plus live");
        irq_chk(1'b1,      "R9 insert irq");
        wr(SA, 32'h0);
        rd_chk(SA, 32'h20, "R3 live bit survives clear");
        @(negedge clk); card_present = 1'b0; tick();
        rd_chk(SA, 32'h08, "R3 removal");
        wr(SA, 32'h0);
        wr(MA, 32'hFFFF_FFFF);
        rd_chk(MA, 32'h1D, "R9 mask A readback");

        // R5: buffer ready edges
        @(negedge clk); rd_buf_full = 1'b1; tick();
        rd_chk(SB, 32'h100, "R5 read ready edge");
        wr(SB, 32'h0);
        rd_chk(SB, 32'h000, "R5 no re-set while full");
        @(negedge clk); rd_buf_full = 1'b0; tick();
        rd_chk(SB, 32'h000, "R5 falling level no set");
        @(negedge clk); rd_buf_full = 1'b1; tick();
        rd_chk(SB, 32'h100, "R5 read ready second edge");
        @(negedge clk); wr_buf_empty = 1'b1; tick();
        rd_chk(SB, 32'h300, "R5 write ready edge");
        @(negedge clk); rd_buf_full = 1'b0; wr_buf_empty = 1'b0; tick();
        wr(SB, 32'h0);

        // R4: error pulses
        @(negedge clk); ev_err = 7'h55; tick();
        rd_chk(SB, 32'h55, "R4 error bits");
        @(negedge clk); ev_illegal_access = 1'b1; tick();
        rd_chk(SB, 32'h8055, "R4 illegal access");
        wr(SB, ~32'h1);
        rd_chk(SB, 32'h8054, "R7 clear bit0 of B");
        @(negedge clk); ev_err = 7'h2A; tick();
        rd_chk(SB, 32'h807E, "R4 remaining error bits");
        wr(SB, 32'h0);

        // R6: live mirrors
        @(negedge clk); dat0_level = 1'b1; cmd_busy = 1'b1; tick();
        rd_chk(SB, 32'h4080, "R6 live bits");
        wr(SB, 32'h0);
        rd_chk(SB, 32'h4080, "R6 live bits ignore write");
        wr(MB, 32'h0);
        irq_chk(1'b0,        "R9 live bits no irq");
        @(negedge clk); ev_err = 7'h04; tick();
        irq_chk(1'b1,        "R9 error irq");
        rd_chk(SB, 32'h4084, "R4 bit2 with live");
        wr(MB, 32'h4);
        irq_chk(1'b0,        "R9 masked error");
        rd_chk(MB, 32'h4,    "R9 mask B partial");
        wr(MB, 32'hFFFF_FFFF);
        rd_chk(MB, 32'h837F, "R9 mask B readback");

        // R10: unmapped addresses
        wr(12'h048, 32'h0);
        rd_chk(SB, 32'h4084, "R10 unmapped write ignored");
        rd_chk(12'h048, 32'h0, "R10 unmapped read 048");
        rd_chk(12'h034, 32'h0, "R10 unmapped read 034");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule